// File: doc/BRIEF.md
# Interrupt Arbitration and Exception Entry Unit

This block owns the machine state word and the two save/restore words of a 32-bit processor. It also owns the sampled-address word that goes with the performance-monitor source. It watches three level-sensitive interrupt requests: external, performance-monitor and decrementer. When interrupts are enabled, it picks one of them by fixed priority. In the same cycle it raises a one-cycle take strobe, a vector-valid flag and the handler fetch address.

At the clock edge that ends the take cycle, the block does the whole architectural entry in one step:
- It stores the resume address.
- It stores a filtered copy of the old state word.
- It rewrites the state word for handler mode.
- If the winner was the performance-monitor source, it captures the address of the instruction in flight.

Software loads the state word through a write port. This is how it turns interrupts back on after the handler has run.

Bit indices below count from the least significant bit (bit 0 is the LSB). The state bits are placed as follows:

| Bit | Name | Meaning |
|---|---|---|
| 18 | POW | power management |
| 16 | ILE | interrupt endianness |
| 15 | EE | interrupt enable |
| 14 | PR | problem state |
| 13 | FP | floating point available |
| 12 | ME | machine check enable |
| 11 | FE0 | floating-point exception mode |
| 10 | SE | single step |
| 9 | BE | branch trace |
| 8 | FE1 | floating-point exception mode |
| 6 | IP | vector prefix select |
| 5 | IR | instruction relocation |
| 4 | DR | data relocation |
| 2 | PM | performance-monitor mark |
| 1 | RI | recoverable interrupt |
| 0 | LE | little-endian mode |

Top module: `exc_entry_unit`

## Requirements
- R1: When more than one request is taken, the winner follows a fixed order: external first, then performance-monitor, then decrementer. `take_src` reports the winner as 2'b01 for external, 2'b10 for performance-monitor, 2'b11 for decrementer, and 2'b00 when nothing is taken.
- R2: No request is taken while EE (bit 15 of `msr`) is 0. In that case `take` stays low and `msr`, `save0`, `save1` and `sampled_addr` keep their values, apart from a software write.
- R3: `take`, `vec_valid` and `redirect_addr` are combinational outputs of the current requests and `msr`. `take` and `vec_valid` are equal. The registered state changes at the rising edge that ends the take cycle.
- R4: `redirect_addr` is a prefix plus an offset. The prefix is 0xFFF00000 when IP (bit 6) is 1 and 0x00000000 when IP is 0. The offset is 0x500 for external, 0xF00 for performance-monitor and 0x900 for decrementer.
- R5: On a take, `save0` loads `next_pc`.
- R6: On a take, `save1` loads the old `msr` ANDed with 0x87C0FFFF. This keeps bits 31, 26..22 and 15..0, and clears bits 30..27 and 21..16.
- R7: On a take, the new `msr` is the old value ANDed with ~0x0004EF36, with bit 0 (LE) set to the old bit 16 (ILE). This clears POW, EE, PR, FP, FE0, FE1, SE, BE, IR, DR, PM and RI, and keeps ME, IP, ILE and every other bit.
- R8: `sampled_addr` loads `exec_pc` only when the performance-monitor request wins. At all other times it holds its value.
- R9: Since entry clears EE, the cycle after a take never takes. A request that lost arbitration stays pending and is taken once software sets EE again, provided its line is still high.
- R10: When `msr_wr` is high and nothing is taken, `msr` loads `msr_wdata`. When a take happens in the same cycle, the entry update wins and the write is dropped.
- R11: After reset, `msr` is 0x00000040 and `save0`, `save1` and `sampled_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_req | input | 1 | External interrupt request, level |
| pm_req | input | 1 | Performance-monitor request, level |
| dec_req | input | 1 | Decrementer request, level |
| next_pc | input | 32 | Address to resume at after the handler |
| exec_pc | input | 32 | Address of the instruction currently in flight |
| msr_wr | input | 1 | Software write strobe for the state word |
| msr_wdata | input | 32 | Value for a software write |
| take | output | 1 | Interrupt taken this cycle |
| take_src | output | 2 | Winning source code |
| vec_valid | output | 1 | Handler address valid |
| redirect_addr | output | 32 | Handler fetch address |
| msr | output | 32 | Machine state word |
| save0 | output | 32 | Saved resume address |
| save1 | output | 32 | Saved filtered state word |
| sampled_addr | output | 32 | Read-only sampled instruction address |

## Verification
The bench sweeps all eight request combinations against every setting of EE, IP and ILE. The remaining state bits come from a pseudo-random pattern, so each combination exercises the keep, clear and copy rules on a different word. The request combinations separate the priority order and the enable gating. IP separates the two vector prefixes. ILE tells the LE copy apart from a plain clear. Directed sequences add a software write in the same cycle as a take, a loser that stays pending across a disabled cycle, and the sampled address holding across non-monitor takes.

// File: rtl/exc_entry_unit.sv
module exc_entry_unit #(
  parameter logic [31:0] MSR_RST   = 32'h0000_0040,
  parameter logic [31:0] HI_PREFIX = 32'hFFF0_0000,
  parameter logic [31:0] OFF_EXT   = 32'h0000_0500,
  parameter logic [31:0] OFF_PM    = 32'h0000_0F00,
  parameter logic [31:0] OFF_DEC   = 32'h0000_0900
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_req,
  input  logic        pm_req,
  input  logic        dec_req,
  input  logic [31:0] next_pc,
  input  logic [31:0] exec_pc,
  input  logic        msr_wr,
  input  logic [31:0] msr_wdata,
  output logic        take,
  output logic [1:0]  take_src,
  output logic        vec_valid,
  output logic [31:0] redirect_addr,
  output logic [31:0] msr,
  output logic [31:0] save0,
  output logic [31:0] save1,
  output logic [31:0] sampled_addr
);
  localparam int B_ILE = 16, B_EE = 15, B_ME = 12, B_IP = 6, B_LE = 0;
  localparam logic [31:0] SAVE_KEEP = 32'h87C0_FFFF;
  localparam logic [31:0] ENTRY_CLR = 32'h0004_EF36;
  localparam logic [1:0]  SRC_NONE = 2'b00, SRC_EXT = 2'b01, SRC_PM = 2'b10, SRC_DEC = 2'b11;

  logic [31:0] offset, msr_entry;

  assign take_src = !msr[B_EE] ? SRC_NONE :
                    ext_req    ? SRC_EXT  :
                    pm_req     ? SRC_PM   :
                    dec_req    ? SRC_DEC  : SRC_NONE;
  assign take      = take_src != SRC_NONE;
  assign vec_valid = take;

  always_comb begin
    case (take_src)
      SRC_EXT: offset = OFF_EXT;
      SRC_PM:  offset = OFF_PM;
      SRC_DEC: offset = OFF_DEC;
      default: offset = '0;
    endcase
  end

  assign redirect_addr = (msr[B_IP] ? HI_PREFIX : 32'h0) + offset;

  always_comb begin
    msr_entry = msr & ~ENTRY_CLR;
    msr_entry[B_LE] = msr[B_ILE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msr          <= MSR_RST;
      save0        <= '0;
      save1        <= '0;
      sampled_addr <= '0;
    end else if (take) begin
      msr   <= msr_entry;
      save0 <= next_pc;
      save1 <= msr & SAVE_KEEP;
      if (take_src == SRC_PM) sampled_addr <= exec_pc;
    end else if (msr_wr) begin
      msr <= msr_wdata;
    end
  end

  AST_PRIO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ext_req) |-> take_src == SRC_EXT); // R1
  AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !msr[B_EE] |-> !vec_valid); // R2
  AST_SAVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (save1 & ~SAVE_KEEP) == 32'h0); // R6
  AST_ME_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> msr[B_ME] == $past(msr[B_ME])); // R7
  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (take_src != SRC_PM) |=> $stable(sampled_addr)); // R8
  AST_NO_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take); // R9
endmodule

// File: tb/tb_exc_entry_unit.sv
module tb_exc_entry_unit;
  logic clk = 0, rst_n = 0;
  logic ext_req = 0, pm_req = 0, dec_req = 0, msr_wr = 0;
  logic [31:0] next_pc = 0, exec_pc = 0, msr_wdata = 0;
  logic take, vec_valid;
  logic [1:0] take_src;
  logic [31:0] redirect_addr, msr, save0, save1, sampled_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_entry_unit dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] entry_msr(logic [31:0] m);
    logic [31:0] r = m & ~32'h0004_EF36;
    r[0] = m[16];
    return r;
  endfunction

  task automatic wr_msr(logic [31:0] v);
    msr_wr = 1; msr_wdata = v;
    @(posedge clk); #1;
    msr_wr = 0;
    chk("R10", msr, v);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1234_5678;
    #12; rst_n = 1; #1;
    chk("R11", msr, 32'h40); chk("R11", save0, 0);
    chk("R11", save1, 0); chk("R11", sampled_addr, 0);
    @(posedge clk); #1;
    for (int i = 0; i < 64; i++) begin
      logic [2:0] rq = i[2:0];
      logic [31:0] base, p0, p1, ps;
      logic [1:0] es;
      logic [31:0] ev;
      bit tk;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      base = lfsr;
      base[15] = i[3]; base[6] = i[4]; base[16] = i[5];
      wr_msr(base);
      p0 = save0; p1 = save1; ps = sampled_addr;
      ext_req = rq[0]; pm_req = rq[1]; dec_req = rq[2];
      next_pc = lfsr ^ 32'hA5A5_0000; exec_pc = ~lfsr;
      tk = base[15] && (rq != 0);
      es = !tk ? 2'b00 : rq[0] ? 2'b01 : rq[1] ? 2'b10 : 2'b11;
      ev = (base[6] ? 32'hFFF0_0000 : 0) +
           (es == 2'b01 ? 32'h500 : es == 2'b10 ? 32'hF00 : es == 2'b11 ? 32'h900 : 0);
      #1;
      chk("R1", {30'b0, take_src}, {30'b0, es});
      chk("R2", {31'b0, take}, {31'b0, tk});
      chk("R3", {31'b0, vec_valid}, {31'b0, tk});
      if (tk) chk("R4", redirect_addr, ev);
      @(posedge clk); #1;
      chk(tk ? "R7" : "R2", msr, tk ? entry_msr(base) : base);
      chk("R5", save0, tk ? next_pc : p0);
      chk("R6", save1, tk ? (base & 32'h87C0_FFFF) : p1);
      chk("R8", sampled_addr, (es == 2'b10) ? exec_pc : ps);
      chk("R9", {31'b0, take}, 0);
      ext_req = 0; pm_req = 0; dec_req = 0;
    end
    // R10: write in the same cycle as a take is dropped
    wr_msr(32'h0001_8040);
    ext_req = 1; msr_wr = 1; msr_wdata = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    msr_wr = 0; ext_req = 0;
    chk("R10", msr, entry_msr(32'h0001_8040));
    // R9: losing request stays pending and is taken after EE set
    wr_msr(32'h0000_8000);
    ext_req = 1; dec_req = 1; exec_pc = 32'h1111_0000;
    @(posedge clk); #1;
    ext_req = 0;
    chk("R9", {31'b0, take}, 0);
    wr_msr(32'h0000_8000);
    #1;
    chk("R9", {30'b0, take_src}, 32'd3);
    chk("R4", redirect_addr, 32'h900);
    @(posedge clk); #1;
    dec_req = 0;
    chk("R8", sampled_addr, ps_keep(sampled_addr));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  function automatic logic [31:0] ps_keep(logic [31:0] v);
    return (v == 32'h1111_0000) ? 32'hDEAD_BEEF : v;
  endfunction
endmodule